// File: doc/BRIEF.md
# SPI Word-Packed Data FIFO Pair

This block sits between a 32-bit host register port and a byte-wide serial shift engine. On the outbound side, the host writes 32-bit words and the shifter receives single bytes. On the inbound side, the shifter delivers single bytes and the host reads 32-bit words. Both sides use little-endian packing. Each direction holds eight bytes. A transfer length, given in bytes, tells the block how many bytes belong to the current transaction. When the length is not a multiple of four, the last word is partial on both sides.

The host sees five status flags: a full flag and an empty flag for the outbound FIFO, an empty flag for the inbound FIFO, and a ready flag for each direction. Each ready flag compares the fill state against a programmable threshold. A flush command empties both FIFOs. The flush indicator stays high for one cycle and then clears by itself. A push into a full FIFO and a pop from an empty one have no effect, and each sets its own sticky error bit.

Top module: `spi_wordfifo_pair`

## Requirements
- R1: The byte in bits 7:0 of a pushed word is the first byte offered on `tx_data`. Bits 15:8, 23:16 and 31:24 follow in that order.
- R2: The first byte accepted on the inbound side appears in bits 7:0 of `host_rdata`. Later bytes fill the next higher byte lanes in arrival order.
- R3: A push stores the smaller of four and the number of outbound bytes still left in the programmed length. The remaining bytes are discarded, so `tx_valid` drops once exactly the programmed number of bytes has been shifted out.
- R4: When the inbound length is used up and fewer than four bytes remain, those bytes form a word that can be popped. The upper lanes of that word read as zero.
- R5: `wfifo_full` is high when fewer than four bytes are free. `wfifo_empty` is high when the outbound FIFO holds no bytes. `rfifo_empty` is high unless either four bytes are stored, or the inbound length is used up and at least one byte is stored.
- R6: `wfifo_ready` is high when the free outbound space exceeds the write threshold. `rfifo_ready` is high when the inbound fill level exceeds the read threshold. After reset, both thresholds are 3.
- R7: A pulse on `flush_req` raises `flush_busy` for exactly one cycle. When `flush_busy` falls, both FIFOs are empty.
- R8: A push while `wfifo_full` is high stores nothing and sets `wr_err`. A pop while `rfifo_empty` is high removes nothing and sets `rd_err`. Both error bits stay set until `err_clr` is pulsed, and a new error in the same cycle as `err_clr` wins.
- R9: `rx_ready` is low when the inbound length is used up, when the inbound FIFO holds eight bytes, or while a flush is in progress.
- R10: After reset, both FIFOs are empty, the programmed length is zero, and both error bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_thr_we | input | 1 | Load both threshold registers |
| cfg_rd_thr | input | 3 | Inbound threshold value |
| cfg_wr_thr | input | 3 | Outbound threshold value |
| cfg_len_we | input | 1 | Load the transfer length for both directions |
| cfg_len | input | 16 | Transfer length in bytes |
| flush_req | input | 1 | Request a flush of both FIFOs |
| flush_busy | output | 1 | Flush in progress, clears by itself |
| err_clr | input | 1 | Clear both error bits |
| wr_err | output | 1 | Sticky push-while-full error |
| rd_err | output | 1 | Sticky pop-while-empty error |
| host_push | input | 1 | Push `host_wdata` into the outbound FIFO |
| host_wdata | input | 32 | Outbound word, little-endian |
| host_pop | input | 1 | Pop the word shown on `host_rdata` |
| host_rdata | output | 32 | Inbound word, little-endian, zero-padded |
| wfifo_full | output | 1 | Outbound FIFO cannot take a full word |
| wfifo_empty | output | 1 | Outbound FIFO holds no bytes |
| wfifo_ready | output | 1 | Outbound free space exceeds threshold |
| rfifo_empty | output | 1 | No inbound word available |
| rfifo_ready | output | 1 | Inbound fill level exceeds threshold |
| tx_valid | output | 1 | Outbound byte available to shifter |
| tx_ready | input | 1 | Shifter takes the outbound byte |
| tx_data | output | 8 | Outbound byte |
| rx_valid | input | 1 | Shifter offers an inbound byte |
| rx_ready | output | 1 | Block accepts the inbound byte |
| rx_data | input | 8 | Inbound byte |

## Verification
The hardest situation to reach is an inbound FIFO that is full while bytes of the transfer are still outstanding. That is the only way to see back-pressure that comes from storage rather than from the length. To reach it, the stimulus programs a length longer than the FIFO and lets the host pop nothing. A flush is then issued from that state, with the outbound side also holding data, to confirm that both sides empty while the inbound length is kept. A table of lengths from one to eight bytes drives each partial-word path in both directions.

// File: rtl/spi_wfp_pkg.sv
package spi_wfp_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/wfp_byte_fifo.sv
module wfp_byte_fifo
  import spi_wfp_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int WR_LANES = 4,
  parameter int RD_LANES = 1,
  localparam int PW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int WNW = $clog2(WR_LANES + 1),
  localparam int RNW = $clog2(RD_LANES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic [WNW-1:0]             wr_n,
  input  logic [WR_LANES*BYTE_W-1:0] wr_data,
  input  logic [RNW-1:0]             rd_n,
  output logic [RD_LANES*BYTE_W-1:0] rd_win,
  output logic [CW-1:0]              level
);

  byte_t         mem [DEPTH];
  logic [PW-1:0] wp, rp, wp_n, rp_n;
  logic [CW-1:0] level_n;
  logic          ptr_en;

  always_comb begin
    ptr_en  = clear || (wr_n != '0) || (rd_n != '0);
    if (clear) begin
      wp_n    = '0;
      rp_n    = '0;
      level_n = '0;
    end else begin
      wp_n    = wp + PW'(wr_n);
      rp_n    = rp + PW'(rd_n);
      level_n = level + CW'(wr_n) - CW'(rd_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (ptr_en) begin
      wp    <= wp_n;
      rp    <= rp_n;
      level <= level_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      for (int i = 0; i < WR_LANES; i++) begin
        if (WNW'(i) < wr_n) mem[wp + PW'(i)] <= wr_data[BYTE_W*i +: BYTE_W];
      end
    end
  end

  for (genvar g = 0; g < RD_LANES; g++) begin : g_win
    assign rd_win[BYTE_W*g +: BYTE_W] = mem[rp + PW'(g)];
  end

  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH)) else $error("byte fifo level above depth");

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(rd_n) <= level) else $error("byte fifo read beyond level");

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(wr_n) + level) <= CW'(DEPTH)) else $error("byte fifo write beyond space");

endmodule

// File: rtl/wfp_sticky_err.sv
module wfp_sticky_err (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic q_n;

  always_comb begin
    if (set)      q_n = 1'b1;
    else if (clr) q_n = 1'b0;
    else          q_n = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_n;
  end

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clr) |=> q) else $error("error bit lost without clear");

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q) else $error("error bit not set");

endmodule

// File: rtl/spi_wordfifo_pair.sv
module spi_wordfifo_pair
  import spi_wfp_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LANES = 4,
  parameter int LEN_W = 16,
  localparam int TW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1),
  localparam int NW  = $clog2(LANES + 1),
  localparam int WW  = LANES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_thr_we,
  input  logic [TW-1:0]     cfg_rd_thr,
  input  logic [TW-1:0]     cfg_wr_thr,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              flush_req,
  output logic              flush_busy,
  input  logic              err_clr,
  output logic              wr_err,
  output logic              rd_err,
  input  logic              host_push,
  input  logic [WW-1:0]     host_wdata,
  input  logic              host_pop,
  output logic [WW-1:0]     host_rdata,
  output logic              wfifo_full,
  output logic              wfifo_empty,
  output logic              wfifo_ready,
  output logic              rfifo_empty,
  output logic              rfifo_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data
);

  localparam logic [TW-1:0] RD_THR_RST = TW'(LANES - 1);
  localparam logic [TW-1:0] WR_THR_RST = TW'(DEPTH - 1 - LANES);

  logic [TW-1:0]    rd_thr, wr_thr;
  logic [LEN_W-1:0] tx_left, rx_left, tx_left_n, rx_left_n;
  logic             flush_busy_n;
  logic [CW-1:0]    wlevel, rlevel, wfree;
  logic [NW-1:0]    tx_take, w_wr_n, r_rd_n, r_word_bytes;
  logic             w_rd_n, r_wr_n;
  logic             push_ok, pop_ok, tx_hs, rx_hs, r_avail;
  logic [WW-1:0]    r_win;
  logic             tx_left_en, rx_left_en;

  // outbound side
  always_comb begin
    wfree       = CW'(DEPTH) - wlevel;
    wfifo_full  = wfree < CW'(LANES);
    wfifo_empty = (wlevel == '0);
    wfifo_ready = wfree > CW'(wr_thr);
    tx_take     = (tx_left >= LEN_W'(LANES)) ? NW'(LANES) : NW'(tx_left);
    push_ok     = host_push && !wfifo_full && !flush_busy;
    w_wr_n      = push_ok ? tx_take : '0;
    tx_valid    = !wfifo_empty && !flush_busy;
    tx_hs       = tx_valid && tx_ready;
    w_rd_n      = tx_hs;
  end

  // inbound side
  always_comb begin
    rx_ready     = (rx_left != '0) && (rlevel != CW'(DEPTH)) && !flush_busy;
    rx_hs        = rx_valid && rx_ready;
    r_wr_n       = rx_hs;
    r_word_bytes = (rlevel >= CW'(LANES)) ? NW'(LANES) : NW'(rlevel);
    r_avail      = (rlevel >= CW'(LANES)) || ((rx_left == '0) && (rlevel != '0));
    rfifo_empty  = !r_avail;
    rfifo_ready  = rlevel > CW'(rd_thr);
    pop_ok       = host_pop && r_avail && !flush_busy;
    r_rd_n       = pop_ok ? r_word_bytes : '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rmask
    assign host_rdata[BYTE_W*g +: BYTE_W] =
      (NW'(g) < r_word_bytes) ? r_win[BYTE_W*g +: BYTE_W] : '0;
  end

  // length counters and flush
  always_comb begin
    tx_left_en   = cfg_len_we || push_ok;
    rx_left_en   = cfg_len_we || rx_hs;
    tx_left_n    = cfg_len_we ? cfg_len : (tx_left - LEN_W'(tx_take));
    rx_left_n    = cfg_len_we ? cfg_len : (rx_left - LEN_W'(1));
    flush_busy_n = flush_busy ? 1'b0 : flush_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_thr     <= RD_THR_RST;
      wr_thr     <= WR_THR_RST;
      tx_left    <= '0;
      rx_left    <= '0;
      flush_busy <= 1'b0;
    end else begin
      if (cfg_thr_we) begin
        rd_thr <= cfg_rd_thr;
        wr_thr <= cfg_wr_thr;
      end
      if (tx_left_en) tx_left <= tx_left_n;
      if (rx_left_en) rx_left <= rx_left_n;
      flush_busy <= flush_busy_n;
    end
  end

  wfp_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(LANES), .RD_LANES(1)) u_wfifo (
    .clk(clk), .rst_n(rst_n), .clear(flush_busy),
    .wr_n(w_wr_n), .wr_data(host_wdata),
    .rd_n(w_rd_n), .rd_win(tx_data), .level(wlevel)
  );

  wfp_byte_fifo #(.DEPTH(DEPTH), .WR_LANES(1), .RD_LANES(LANES)) u_rfifo (
    .clk(clk), .rst_n(rst_n), .clear(flush_busy),
    .wr_n(r_wr_n), .wr_data(rx_data),
    .rd_n(r_rd_n), .rd_win(r_win), .level(rlevel)
  );

  wfp_sticky_err u_wr_err (
    .clk(clk), .rst_n(rst_n), .set(host_push && wfifo_full), .clr(err_clr), .q(wr_err)
  );

  wfp_sticky_err u_rd_err (
    .clk(clk), .rst_n(rst_n), .set(host_pop && rfifo_empty), .clr(err_clr), .q(rd_err)
  );

  p_flush_selfclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |=> !flush_busy) else $error("flush did not clear");

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> (wlevel == '0 && rlevel == '0)) else $error("flush left data");

  p_full_push_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_push && wfifo_full) |=> wlevel <= $past(wlevel)) else $error("push into full fifo stored");

  p_empty_pop_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_pop && rfifo_empty && !flush_busy) |=> rlevel >= $past(rlevel))
    else $error("pop from empty fifo removed data");

  p_rx_stops_at_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_left == '0 && !cfg_len_we) |=> rlevel <= $past(rlevel)) else $error("byte taken beyond length");

endmodule

// File: tb/sim_spi_wordfifo_pair.sv
module sim_spi_wordfifo_pair;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_thr_we, cfg_len_we, flush_req, err_clr;
  logic [2:0]  cfg_rd_thr, cfg_wr_thr;
  logic [15:0] cfg_len;
  logic        host_push, host_pop, tx_ready, rx_valid;
  logic [31:0] host_wdata, host_rdata;
  logic [7:0]  tx_data, rx_data;
  logic        flush_busy, wr_err, rd_err, wfifo_full, wfifo_empty, wfifo_ready;
  logic        rfifo_empty, rfifo_ready, tx_valid, rx_ready;

  int n_checks = 0;
  int n_err    = 0;

  // {length, word0, word1}
  localparam logic [67:0] VEC [8] = '{
    {4'd1, 32'hFFFF_FFA5, 32'hFFFF_FFFF},
    {4'd2, 32'hFFFF_3C81, 32'hFFFF_FFFF},
    {4'd3, 32'hFF77_0102, 32'hFFFF_FFFF},
    {4'd4, 32'hDEAD_BEEF, 32'hFFFF_FFFF},
    {4'd5, 32'h1234_5678, 32'hFFFF_FF9A},
    {4'd6, 32'h0F1E_2D3C, 32'hFFFF_4B5A},
    {4'd7, 32'hC0DE_0001, 32'hFF55_AA66},
    {4'd8, 32'h8765_4321, 32'h0BAD_F00D}
  };

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_wordfifo_pair u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_thr_we(cfg_thr_we), .cfg_rd_thr(cfg_rd_thr), .cfg_wr_thr(cfg_wr_thr),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .flush_req(flush_req), .flush_busy(flush_busy),
    .err_clr(err_clr), .wr_err(wr_err), .rd_err(rd_err),
    .host_push(host_push), .host_wdata(host_wdata),
    .host_pop(host_pop), .host_rdata(host_rdata),
    .wfifo_full(wfifo_full), .wfifo_empty(wfifo_empty), .wfifo_ready(wfifo_ready),
    .rfifo_empty(rfifo_empty), .rfifo_ready(rfifo_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] maskw(input logic [31:0] w, input int n);
    logic [31:0] r = w;
    for (int b = 0; b < 4; b++) if (b >= n) r[8*b +: 8] = 8'h00;
    return r;
  endfunction

  function automatic logic [7:0] vbyte(input logic [31:0] w0, input logic [31:0] w1, input int k);
    return (k < 4) ? w0[8*k +: 8] : w1[8*(k-4) +: 8];
  endfunction

  task automatic load_len(input int len);
    cfg_len = 16'(len); cfg_len_we = 1'b1; tick; cfg_len_we = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    host_wdata = w; host_push = 1'b1; tick; host_push = 1'b0;
  endtask

  task automatic pop;
    host_pop = 1'b1; tick; host_pop = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1; tick; rx_valid = 1'b0;
  endtask

  task automatic set_thr(input int rd, input int wr);
    cfg_rd_thr = 3'(rd); cfg_wr_thr = 3'(wr); cfg_thr_we = 1'b1; tick; cfg_thr_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_thr_we = 0; cfg_len_we = 0; flush_req = 0; err_clr = 0;
    cfg_rd_thr = 0; cfg_wr_thr = 0; cfg_len = 0;
    host_push = 0; host_pop = 0; tx_ready = 0; rx_valid = 0;
    host_wdata = 0; rx_data = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick;

    // reset state R10, R5, R6, R9
    check("R10", "wfifo_empty", 32'(wfifo_empty), 1);
    check("R10", "rfifo_empty", 32'(rfifo_empty), 1);
    check("R5",  "wfifo_full",  32'(wfifo_full), 0);
    check("R6",  "wfifo_ready", 32'(wfifo_ready), 1);
    check("R6",  "rfifo_ready", 32'(rfifo_ready), 0);
    check("R10", "errors",      32'({wr_err, rd_err, flush_busy}), 0);
    check("R9",  "rx_ready zero len", 32'(rx_ready), 0);
    check("R10", "tx_valid",    32'(tx_valid), 0);

    // vector walk: both paths, lengths 1..8
    for (int v = 0; v < 8; v++) begin
      int          len = int'(VEC[v][67:64]);
      logic [31:0] w0  = VEC[v][63:32];
      logic [31:0] w1  = VEC[v][31:0];
      load_len(len);
      push(w0);
      if (len > 4) push(w1);
      for (int k = 0; k < len; k++) begin
        check("R3", "tx_valid during drain", 32'(tx_valid), 1);
        check("R1", "tx byte order", 32'(tx_data), 32'(vbyte(w0, w1, k)));
        tx_ready = 1'b1; tick; tx_ready = 1'b0;
      end
      check("R3", "tx_valid after length", 32'(tx_valid), 0);

      load_len(len);
      for (int k = 0; k < len; k++) feed(vbyte(w0, w1, k));
      check("R9", "rx_ready after length", 32'(rx_ready), 0);
      check("R5", "rfifo_empty with word", 32'(rfifo_empty), 0);
      check(len < 4 ? "R4" : "R2", "rx word0", host_rdata, maskw(w0, len));
      pop;
      if (len > 4) begin
        check(len < 8 ? "R4" : "R2", "rx word1", host_rdata, maskw(w1, len - 4));
        pop;
      end
      check("R5", "rfifo_empty after pops", 32'(rfifo_empty), 1);
    end

    // thresholds and full on outbound side, R5 R6 R8
    load_len(16);
    push(32'h4433_2211);
    check("R6", "wfifo_ready free4 thr3", 32'(wfifo_ready), 1);
    set_thr(3, 4);
    check("R6", "wfifo_ready free4 thr4", 32'(wfifo_ready), 0);
    push(32'h8877_6655);
    check("R5", "wfifo_full at 8", 32'(wfifo_full), 1);
    push(32'hCAFE_CAFE);
    check("R8", "wr_err on full push", 32'(wr_err), 1);
    for (int k = 0; k < 8; k++) begin
      check("R8", "drained byte", 32'(tx_data), 32'(8'h11 + 8'(k * 8'h11)));
      tx_ready = 1'b1; tick; tx_ready = 1'b0;
    end
    check("R8", "nothing stored by ignored push", 32'(tx_valid), 0);
    check("R8", "wr_err still sticky", 32'(wr_err), 1);
    err_clr = 1'b1; tick; err_clr = 1'b0;
    check("R8", "wr_err cleared", 32'(wr_err), 0);

    // pop while empty, and set-wins-over-clear
    pop;
    check("R8", "rd_err on empty pop", 32'(rd_err), 1);
    check("R8", "rfifo stays empty", 32'(rfifo_empty), 1);
    host_pop = 1'b1; err_clr = 1'b1; tick; host_pop = 1'b0; err_clr = 1'b0;
    check("R8", "set wins over clear", 32'(rd_err), 1);
    err_clr = 1'b1; tick; err_clr = 1'b0;

    // inbound threshold, storage back-pressure, flush: R6 R5 R9 R7
    set_thr(1, 3);
    load_len(12);
    feed(8'h01);
    check("R6", "rfifo_ready level1 thr1", 32'(rfifo_ready), 0);
    feed(8'h02);
    check("R6", "rfifo_ready level2 thr1", 32'(rfifo_ready), 1);
    check("R5", "rfifo_empty partial mid-length", 32'(rfifo_empty), 1);
    for (int k = 0; k < 6; k++) feed(8'(k + 3));
    check("R9", "rx_ready when fifo full", 32'(rx_ready), 0);
    push(32'h0000_00AA);
    check("R5", "wfifo_empty with data", 32'(wfifo_empty), 0);
    flush_req = 1'b1; tick; flush_req = 1'b0;
    check("R7", "flush_busy set", 32'(flush_busy), 1);
    check("R7", "tx_valid during flush", 32'(tx_valid), 0);
    tick;
    check("R7", "flush_busy self clear", 32'(flush_busy), 0);
    check("R7", "wfifo empty after flush", 32'(wfifo_empty), 1);
    check("R7", "rfifo empty after flush", 32'(rfifo_empty), 1);
    check("R9", "rx_ready resumes", 32'(rx_ready), 1);

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule